// File: doc/BRIEF.md
# Discrete-Input SPI Snapshot Shifter

This block reads eight discrete input bits and returns them over a three-wire serial read port. The port has an active-low select, a serial clock and a serial return line. A fourth wire carries serial data in from an upstream device, so several blocks can be chained on one select. When the select goes active, all eight inputs are captured at once into a shift register. Each rising serial clock edge while the block is selected moves the register one place toward its top stage and pulls the next upstream bit into the bottom stage. The return line always shows the top stage.

All logic runs on one fast system clock. The select, serial clock and upstream data pins are each passed through a two-flop synchroniser before their edges are detected, so the system clock must run at least four times faster than the serial clock. The tri-state return pin is modelled as a data bit plus a separate output enable. The serial pins carry no valid/ready handshake: the reader sets the pace with its clock and cannot be held back.

Top module: `discrete_spi_shifter`

## Requirements
- R1: A falling edge on `spi_sel_n` copies `par_in` into the register, with `par_in[i]` in stage i+1. Before any serial clock edge, `spi_dout` then shows `par_in[7]`.
- R2: Each rising edge of `spi_clk` while `spi_sel_n` is low shifts every stage one place toward stage 8 and loads stage 1 from `spi_din`. The bits therefore leave on `spi_dout` in the order `par_in[7]` down to `par_in[0]`.
- R3: In a 16-clock read, the eight local bits come out first. The bits received on `spi_din` follow, in the same order they arrived. If `spi_din` is held at 0, zeros fill in behind the data.
- R4: `spi_dout_en` is 1 while the synchronised select is low and 0 while it is high. It follows a change on `spi_sel_n` after three system clocks.
- R5: While `spi_sel_n` is high, `spi_clk` edges leave the register unchanged. `spi_dout` keeps its value until the next load.
- R6: If a rising `spi_clk` edge is detected in the same system-clock cycle as the select falling edge, the clock edge is ignored. The register holds the freshly loaded inputs.
- R7: A synchronous reset (`rst` high) clears the register, so `spi_dout` reads 0, and deasserts `spi_dout_en`. The edge-detector history is set to select high and clock low.
- R8: Changes on `par_in` after the load have no effect on the bits shifted out in that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | 8 | Discrete input bits, captured when the select goes active |
| spi_sel_n | input | 1 | Active-low select |
| spi_clk | input | 1 | Serial clock; the rising edge shifts the register |
| spi_din | input | 1 | Serial data from the upstream device; 0 when left unconnected |
| spi_dout | output | 1 | Top stage of the shift register |
| spi_dout_en | output | 1 | Output enable of the return pin; 0 means high impedance |

## Verification
The bench aims at five corner cases, each tied to a typical design error.
- A serial clock edge that lands in the same cycle as the select falling edge. A design that shifts there would show `par_in[6]` first instead of `par_in[7]`.
- Clock toggles while the select is high. A design that does not gate them would change `spi_dout` between reads.
- A 16-clock chained read. An off-by-one shift, or shifting the wrong way, would garble or reorder the upstream bits after the eighth clock.
- `par_in` changing in the middle of a read. If the register tracked the inputs instead of capturing them, the new values would leak out.
- Reset state of the output enable. A design that got this wrong would drive the pin out of reset.

// File: rtl/dss_pkg.sv
package dss_pkg;
  // Synchronised pin bundle; field order fixes the bit layout of the sync vector
  typedef struct packed {
    logic sel_n;
    logic sck;
    logic din;
  } spi_pins_t;

  localparam int PIN_COUNT = $bits(spi_pins_t);
  // Idle levels: select high, clock low, data low (pull-down)
  localparam spi_pins_t PINS_IDLE = '{sel_n: 1'b1, sck: 1'b0, din: 1'b0};
endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dss_edge.sv
module dss_edge (
  input  logic clk,
  input  logic rst,
  input  logic sel_n_s,
  input  logic sck_s,
  output logic sel_fall,
  output logic sck_rise
);
  logic sel_prev, sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      sel_prev <= sel_n_s;
      sck_prev <= sck_s;
    end
  end

  assign sel_fall = sel_prev & ~sel_n_s;
  // Only clock edges seen while selected count
  assign sck_rise = ~sck_prev & sck_s & ~sel_n_s;
endmodule

// File: rtl/dss_shreg.sv
module dss_shreg #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [NBITS-1:0] par,
  input  logic             ser_in,
  output logic [NBITS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= par;
    else if (shift) q <= {q[NBITS-2:0], ser_in};
  end
endmodule

// File: rtl/discrete_spi_shifter.sv
module discrete_spi_shifter #(
  parameter int NBITS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] par_in,
  input  logic             spi_sel_n,
  input  logic             spi_clk,
  input  logic             spi_din,
  output logic             spi_dout,
  output logic             spi_dout_en
);
  import dss_pkg::*;

  spi_pins_t pins_raw, pins_s;
  logic sel_fall, sck_rise_raw, do_shift;
  logic [NBITS-1:0] sreg_q;
  logic oe_q;

  assign pins_raw = '{sel_n: spi_sel_n, sck: spi_clk, din: spi_din};

  dss_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  dss_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .sel_n_s  (pins_s.sel_n),
    .sck_s    (pins_s.sck),
    .sel_fall (sel_fall),
    .sck_rise (sck_rise_raw)
  );

  // Load wins over a coincident clock edge
  assign do_shift = sck_rise_raw & ~sel_fall;

  dss_shreg #(.NBITS(NBITS)) u_shreg (
    .clk    (clk),
    .rst    (rst),
    .load   (sel_fall),
    .shift  (do_shift),
    .par    (par_in),
    .ser_in (pins_s.din),
    .q      (sreg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= ~pins_s.sel_n;
  end

  assign spi_dout    = sreg_q[NBITS-1];
  assign spi_dout_en = oe_q;
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_n,
  input logic [NBITS-1:0] par_in,
  input logic             dout_en,
  input logic             dout,
  input logic [NBITS-1:0] sreg,
  input logic             din_s,
  input logic             sel_n_s,
  input logic             sel_fall,
  input logic             sck_rise
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    sel_fall |=> (sreg == $past(par_in)));

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sck_rise && !sel_fall) |=> (sreg == {$past(sreg[NBITS-2:0]), $past(din_s)}));

  // R4
  enable_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (dout_en == !$past(sel_n, 3)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> $stable(sreg));

  // R6
  coincident_load_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_fall && sck_rise) |=> (sreg == $past(par_in)));

  // R7
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (sreg == '0 && !dout_en && !dout));
endmodule

bind discrete_spi_shifter dss_checker #(.NBITS(NBITS)) u_dss_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_n    (spi_sel_n),
  .par_in   (par_in),
  .dout_en  (spi_dout_en),
  .dout     (spi_dout),
  .sreg     (sreg_q),
  .din_s    (pins_s.din),
  .sel_n_s  (pins_s.sel_n),
  .sel_fall (sel_fall),
  .sck_rise (sck_rise_raw)
);

// File: tb/test_discrete_spi_shifter.sv
module test_discrete_spi_shifter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] par_in = 8'h00;
  logic       spi_sel_n = 1'b1;
  logic       spi_clk = 1'b0;
  logic       spi_din = 1'b0;
  logic       spi_dout, spi_dout_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic  v;
    logic  en;
    string rq;
  } exp_t;
  exp_t exp_q[$];
  bit   smp = 0;

  always #2.5 clk = ~clk;

  discrete_spi_shifter i_discrete_spi_shifter (
    .clk(clk), .rst(rst), .par_in(par_in), .spi_sel_n(spi_sel_n),
    .spi_clk(spi_clk), .spi_din(spi_din), .spi_dout(spi_dout),
    .spi_dout_en(spi_dout_en)
  );

  function automatic void check(string rq, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", rq, what, act, exp);
    end
  endfunction

  // Monitor: pops one expected item per sample request
  always @(posedge clk) begin
    if (smp && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.rq, "spi_dout", spi_dout, e.v);
      check(e.rq, "spi_dout_en", spi_dout_en, e.en);
    end
  end

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(logic v, logic en, string rq);
    exp_q.push_back('{v: v, en: en, rq: rq});
    smp = 1;
    @(negedge clk);
    smp = 0;
  endtask

  task automatic pulse_sck(logic din);
    spi_din = din;
    wait_clks(2);
    spi_clk = 1'b1;
    wait_clks(4);
    spi_clk = 1'b0;
    wait_clks(4);
  endtask

  // Read of nclk clocks; upstream bit j is sent on rise j+1
  task automatic read_frame(logic [7:0] pat, logic [15:0] up, int nclk, string rq);
    par_in = pat;
    spi_sel_n = 1'b0;
    wait_clks(6);
    expect_out(pat[7], 1'b1, "R1");
    for (int k = 1; k < nclk; k++) begin
      pulse_sck(up[k-1]);
      if (k < 8) expect_out(pat[7-k], 1'b1, rq);
      else       expect_out(up[k-8], 1'b1, "R3");
    end
    spi_sel_n = 1'b1;
    spi_din = 1'b0;
    wait_clks(6);
    expect_out(spi_dout, 1'b0, "R4");
  endtask

  initial begin
    wait_clks(4);
    // R7: reset state
    check("R7", "spi_dout in reset", spi_dout, 1'b0);
    check("R7", "spi_dout_en in reset", spi_dout_en, 1'b0);
    rst = 1'b0;
    wait_clks(4);
    check("R4", "spi_dout_en idle", spi_dout_en, 1'b0);

    // R1/R2: basic 8-bit read, two patterns
    read_frame(8'hA5, 16'h0000, 8, "R2");
    read_frame(8'h3C, 16'h0000, 8, "R2");

    // R3: chained 16-clock reads, upstream data follows local bits
    read_frame(8'hC9, 16'h00B2, 16, "R2");
    read_frame(8'h81, 16'h004E, 16, "R2");
    // R3: upstream tied low gives zeros behind
    read_frame(8'hFF, 16'h0000, 16, "R2");

    // R5: clock toggles while deselected leave the register alone
    par_in = 8'h96;
    spi_sel_n = 1'b0;
    wait_clks(6);
    pulse_sck(1'b0);
    pulse_sck(1'b0);
    pulse_sck(1'b0);
    expect_out(1'b1, 1'b1, "R2"); // par_in[4] of 10010110
    spi_sel_n = 1'b1;
    wait_clks(6);
    for (int i = 0; i < 5; i++) pulse_sck(1'b1);
    expect_out(1'b1, 1'b0, "R5");
    pulse_sck(1'b0);
    expect_out(1'b1, 1'b0, "R5");

    // R6: clock rise coincident with select fall is ignored
    par_in = 8'h5A;
    spi_sel_n = 1'b0;
    spi_clk = 1'b1;
    wait_clks(6);
    expect_out(1'b0, 1'b1, "R6");   // par_in[7]
    spi_clk = 1'b0;
    wait_clks(4);
    pulse_sck(1'b0);
    expect_out(1'b1, 1'b1, "R6");   // par_in[6]
    spi_sel_n = 1'b1;
    wait_clks(6);

    // R8: par_in changes mid-read do not leak out
    par_in = 8'hE1;
    spi_sel_n = 1'b0;
    wait_clks(6);
    par_in = 8'h1E;
    expect_out(1'b1, 1'b1, "R8");
    for (int k = 1; k < 8; k++) begin
      pulse_sck(1'b0);
      par_in = ~par_in;
      expect_out(8'hE1 >> (7 - k) & 1'b1, 1'b1, "R8");
    end
    spi_sel_n = 1'b1;
    wait_clks(6);

    // R7: reset mid-read clears the register
    par_in = 8'hFF;
    spi_sel_n = 1'b0;
    wait_clks(6);
    rst = 1'b1;
    wait_clks(2);
    check("R7", "spi_dout after reset", spi_dout, 1'b0);
    check("R7", "spi_dout_en after reset", spi_dout_en, 1'b0);
    rst = 1'b0;
    spi_sel_n = 1'b1;
    wait_clks(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule